// File: doc/BRIEF.md
# PCM Delay Line

The block holds back a stereo PCM stream by a programmable number of frames. Each frame brings one left and one right 24-bit sample, marked by a single-cycle frame strobe. Incoming frames go into a ring buffer kept in inferred on-chip RAM. Once the configured number of frames has been stored, every new frame pushes the oldest stored frame out to the outputs.

The delay setting is sampled on every strobe. A new value counts as fixed only after it has been seen unchanged on two consecutive strobes. From the strobe that brings the change until the delayed data starts, the outputs are forced to zero and the mute flag is raised. Setting the delay to zero cancels it. Buffer writes then stop, and the outputs stay silent for a fixed 512 frames before the input is passed straight through. The lock-error input is accepted, but every sequence runs the same whatever its level.

Top module: `pcm_delay_line`

## Requirements
- R1: After synchronous reset, `out_left`, `out_right` and `mute_o` are zero, and the block is in pass-through with no delay.
- R2: The setting is compared at each strobe with the value seen at the previous strobe, after the clamp of R9. A difference mutes the output from that frame on. The setting becomes fixed at the next strobe that shows the same value. A further change before that restarts the sequence.
- R3: Whenever `mute_o` is 1, `out_left` and `out_right` are both zero.
- R4: When a nonzero delay D becomes fixed at strobe S, the outputs for strobes S to S+D-1 are muted. From strobe S+D on, the output at strobe k equals the input frame of strobe k-D.
- R5: A new nonzero value fixed while a delay is active discards the stored frames and restarts filling from the fixing strobe. No frame from before the change is ever output.
- R6: When the setting becomes fixed at zero while a delay was active, writes stop and exactly 512 frames are muted, counted from the fixing strobe. At the next strobe the output equals that strobe's input frame, and `mute_o` drops to 0.
- R7: The level of `lock_err` has no effect on any output.
- R8: Outputs change only on the clock edge that samples `frame_stb` high. Between strobes they hold their values.
- R9: `delay_req` is an unsigned frame count, and 0 means no delay. Values above 4096 act as 4096, so 6000 and 4096 count as the same setting.
- R10: A delay of 1 mutes exactly the fixing frame. From the next strobe on, each output is the previous frame's input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per stereo frame |
| in_left | input | 24 | Left input sample |
| in_right | input | 24 | Right input sample |
| delay_req | input | REQ_W (16) | Requested delay in frames |
| lock_err | input | 1 | Lock-error flag, no effect on the sequence |
| out_left | output | 24 | Delayed or passed left sample |
| out_right | output | 24 | Delayed or passed right sample |
| mute_o | output | 1 | High while the setup sequence forces silence |

## Verification
A frame-by-frame vector table takes the block through pass-through, a 3-frame delay, a change that is replaced before it settles, and a 1-frame delay. Each input frame carries its own index, so an output reveals exactly which frame it came from. Any lag that is off by one, or any stale frame from before a change, shows up as a wrong index. Directed runs count the muted frames after a cancel (512) and after an oversized request (4096 through the clamp). The same table is then replayed with the lock-error flag held high, which shows that the flag changes nothing.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    localparam int SMP_W   = 24;
    localparam int FRAME_W = 2 * SMP_W;

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } frame_t;

    // Controller phase; also tells the output stage where data comes from
    typedef enum logic [2:0] {
        ST_PASS   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_FILL   = 3'd2,
        ST_RUN    = 3'd3,
        ST_CANCEL = 3'd4
    } phase_e;

endpackage

// File: rtl/pdl_settle.sv
module pdl_settle #(
    parameter int REQ_W     = 16,
    parameter int MAX_DELAY = 4096,
    parameter int DW        = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic [REQ_W-1:0] delay_req,
    output logic [DW-1:0]    req_clamped,
    output logic             chg
);
    localparam logic [REQ_W-1:0] MAX_REQ = REQ_W'(MAX_DELAY);

    logic [DW-1:0] seen_q;

    // Oversized requests saturate at the buffer size
    assign req_clamped = (delay_req > MAX_REQ) ? DW'(MAX_DELAY) : delay_req[DW-1:0];
    assign chg         = frame_stb && (req_clamped != seen_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (frame_stb) begin
            seen_q <= req_clamped;
        end
    end

endmodule

// File: rtl/pdl_ctrl.sv
module pdl_ctrl
    import pdl_pkg::*;
#(
    parameter int MAX_DELAY     = 4096,
    parameter int CANCEL_FRAMES = 512,
    parameter int DW            = 13,
    parameter int AW            = 12,
    parameter int CW            = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_stb,
    input  logic          chg,
    input  logic [DW-1:0] req_clamped,
    output phase_e        phase,
    output logic          ram_we,
    output logic          ram_re,
    output logic [AW-1:0] ram_addr,
    output logic          pass_en,
    output logic [DW-1:0] dly_o
);
    logic [DW-1:0] dly_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] wptr_nx;
    logic [DW-1:0] wptr_ext;
    logic          keep;

    assign keep     = frame_stb && !chg;
    assign wptr_ext = DW'(wptr_q) + DW'(1);
    assign wptr_nx  = (wptr_ext >= dly_q) ? '0 : wptr_q + AW'(1);
    assign dly_o    = dly_q;

    // RAM port and output-source selection for the current strobe
    always_comb begin
        ram_we   = 1'b0;
        ram_re   = 1'b0;
        ram_addr = wptr_q;
        pass_en  = 1'b0;
        if (keep) begin
            unique case (phase)
                ST_PASS: pass_en = 1'b1;
                ST_SETTLE: begin
                    if (req_clamped != '0) begin
                        ram_we   = 1'b1;
                        ram_addr = '0;
                    end
                end
                ST_FILL: ram_we = 1'b1;
                ST_RUN: begin
                    ram_we = 1'b1;
                    ram_re = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= ST_PASS;
            dly_q  <= '0;
            cnt_q  <= '0;
            wptr_q <= '0;
        end else if (frame_stb) begin
            if (chg) begin
                phase <= ST_SETTLE;
            end else begin
                unique case (phase)
                    ST_SETTLE: begin
                        cnt_q <= CW'(1);
                        if (req_clamped == '0) begin
                            dly_q <= '0;
                            phase <= (dly_q != '0) ? ST_CANCEL : ST_PASS;
                        end else begin
                            dly_q <= req_clamped;
                            if (req_clamped == DW'(1)) begin
                                wptr_q <= '0;
                                phase  <= ST_RUN;
                            end else begin
                                wptr_q <= AW'(1);
                                phase  <= ST_FILL;
                            end
                        end
                    end
                    ST_FILL: begin
                        wptr_q <= wptr_nx;
                        cnt_q  <= cnt_q + CW'(1);
                        if ((cnt_q + CW'(1)) == CW'(dly_q)) begin
                            phase <= ST_RUN;
                        end
                    end
                    ST_RUN: wptr_q <= wptr_nx;
                    ST_CANCEL: begin
                        cnt_q <= cnt_q + CW'(1);
                        if ((cnt_q + CW'(1)) == CW'(CANCEL_FRAMES)) begin
                            phase <= ST_PASS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pdl_ram.sv
module pdl_ram #(
    parameter int DEPTH = 4096,
    parameter int AW    = 12,
    parameter int W     = 48
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Single port, read-before-write on a shared address
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/pcm_delay_line.sv
module pcm_delay_line
    import pdl_pkg::*;
#(
    parameter int REQ_W         = 16,
    parameter int MAX_DELAY     = 4096,
    parameter int CANCEL_FRAMES = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic [SMP_W-1:0] in_left,
    input  logic [SMP_W-1:0] in_right,
    input  logic [REQ_W-1:0] delay_req,
    input  logic             lock_err,
    output logic [SMP_W-1:0] out_left,
    output logic [SMP_W-1:0] out_right,
    output logic             mute_o
);
    localparam int DW   = $clog2(MAX_DELAY + 1);
    localparam int AW   = $clog2(MAX_DELAY);
    localparam int CANW = $clog2(CANCEL_FRAMES + 1);
    localparam int CW   = (DW > CANW) ? DW : CANW;

    logic [DW-1:0] req_w;
    logic          chg_w;
    phase_e        phase_w;
    logic          we_w;
    logic          re_w;
    logic          pass_w;
    logic [AW-1:0] addr_w;
    logic [DW-1:0] dly_w;
    frame_t        in_frame;
    frame_t        rd_frame;
    frame_t        pass_q;
    frame_t        out_frame;
    logic          run_q;
    logic          mute_q;
    logic          lock_err_unused;

    // The sequence is identical with or without a lock error
    assign lock_err_unused = lock_err;
    assign in_frame        = '{left: in_left, right: in_right};

    pdl_settle #(.REQ_W(REQ_W), .MAX_DELAY(MAX_DELAY), .DW(DW)) u_settle (
        .clk         (clk),
        .rst         (rst),
        .frame_stb   (frame_stb),
        .delay_req   (delay_req),
        .req_clamped (req_w),
        .chg         (chg_w)
    );

    pdl_ctrl #(
        .MAX_DELAY(MAX_DELAY), .CANCEL_FRAMES(CANCEL_FRAMES),
        .DW(DW), .AW(AW), .CW(CW)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .frame_stb   (frame_stb),
        .chg         (chg_w),
        .req_clamped (req_w),
        .phase       (phase_w),
        .ram_we      (we_w),
        .ram_re      (re_w),
        .ram_addr    (addr_w),
        .pass_en     (pass_w),
        .dly_o       (dly_w)
    );

    pdl_ram #(.DEPTH(MAX_DELAY), .AW(AW), .W(FRAME_W)) u_ram (
        .clk   (clk),
        .we    (we_w),
        .re    (re_w),
        .addr  (addr_w),
        .wdata (in_frame),
        .rdata (rd_frame)
    );

    // Output stage: source flag and pass-through register move together
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            pass_q <= '0;
            mute_q <= 1'b0;
        end else if (frame_stb) begin
            run_q  <= re_w;
            pass_q <= pass_w ? in_frame : '0;
            mute_q <= !(pass_w || re_w);
        end
    end

    assign out_frame = run_q ? rd_frame : pass_q;
    assign out_left  = out_frame.left;
    assign out_right = out_frame.right;
    assign mute_o    = mute_q;

endmodule

// File: rtl/pdl_chk.sv
module pdl_chk
    import pdl_pkg::*;
#(
    parameter int MAX_DELAY = 4096,
    parameter int DW        = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_stb,
    input logic             chg,
    input phase_e           phase,
    input logic [DW-1:0]    dly_cur,
    input logic             mute_o,
    input logic [SMP_W-1:0] out_left,
    input logic [SMP_W-1:0] out_right
);

    p_mute_silent_r3: assert property (@(posedge clk) disable iff (rst)
        mute_o |-> (out_left == '0 && out_right == '0));

    p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_stb) |-> ($stable(out_left) && $stable(out_right) && $stable(mute_o)));

    p_change_mutes_r2: assert property (@(posedge clk) disable iff (rst)
        chg |=> mute_o);

    p_setup_muted_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_SETTLE || phase == ST_FILL || phase == ST_CANCEL) |-> mute_o);

    p_clamp_r9: assert property (@(posedge clk) disable iff (rst)
        dly_cur <= DW'(MAX_DELAY));

endmodule

bind pcm_delay_line pdl_chk #(.MAX_DELAY(MAX_DELAY), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .chg       (chg_w),
    .phase     (phase_w),
    .dly_cur   (dly_w),
    .mute_o    (mute_o),
    .out_left  (out_left),
    .out_right (out_right)
);

// File: tb/sim_pcm_delay_line.sv
module sim_pcm_delay_line;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb = 1'b0;
    logic        lock_err = 1'b0;
    logic [15:0] req = '0;
    logic [23:0] in_l = '0;
    logic [23:0] in_r = '0;
    logic [23:0] out_left;
    logic [23:0] out_right;
    logic        mute_o;

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    int cycles = 0;

    // 50 MHz
    always #10 clk = ~clk;

    pcm_delay_line u0 (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (stb),
        .in_left   (in_l),
        .in_right  (in_r),
        .delay_req (req),
        .lock_err  (lock_err),
        .out_left  (out_left),
        .out_right (out_right),
        .mute_o    (mute_o)
    );

    // Vector: {delay_req[15:0], expect_mute, lag[14:0]}
    localparam int NVEC = 22;
    localparam logic [31:0] VEC [NVEC] = '{
        {16'd0, 1'b0, 15'd0}, {16'd0, 1'b0, 15'd0},
        {16'd3, 1'b1, 15'd0}, {16'd3, 1'b1, 15'd0},
        {16'd3, 1'b1, 15'd0}, {16'd3, 1'b1, 15'd0},
        {16'd3, 1'b0, 15'd3}, {16'd3, 1'b0, 15'd3},
        {16'd3, 1'b0, 15'd3}, {16'd2, 1'b1, 15'd0},
        {16'd5, 1'b1, 15'd0}, {16'd5, 1'b1, 15'd0},
        {16'd5, 1'b1, 15'd0}, {16'd5, 1'b1, 15'd0},
        {16'd5, 1'b1, 15'd0}, {16'd5, 1'b1, 15'd0},
        {16'd5, 1'b0, 15'd5}, {16'd5, 1'b0, 15'd5},
        {16'd1, 1'b1, 15'd0}, {16'd1, 1'b1, 15'd0},
        {16'd1, 1'b0, 15'd1}, {16'd1, 1'b0, 15'd1}
    };

    function automatic logic [23:0] smp_l(input int i);
        return 24'h100000 | 24'(i);
    endfunction

    function automatic logic [23:0] smp_r(input int i);
        return 24'h400000 | 24'(i);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (frame %0d)", tag, act, exp, k);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // One frame: strobe for one cycle, then check that the outputs hold (R8)
    task automatic frame(input logic [15:0] r);
        logic [48:0] snap;
        @(negedge clk);
        req  = r;
        in_l = smp_l(k);
        in_r = smp_r(k);
        stb  = 1'b1;
        @(negedge clk);
        stb  = 1'b0;
        snap = {mute_o, out_left, out_right};
        @(negedge clk);
        chk("R8 hold between strobes", {mute_o, out_left, out_right}, snap);
    endtask

    task automatic expect_frame(input string tag, input logic m, input int lag);
        if (m) begin
            chk({tag, " mute flag"}, mute_o, 1'b1);
            chk({tag, " R3 muted data"}, {out_left, out_right}, 48'h0);
        end else begin
            chk({tag, " mute flag"}, mute_o, 1'b0);
            chk({tag, " data"}, {out_left, out_right}, {smp_l(k - lag), smp_r(k - lag)});
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        stb = 1'b0;
        req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        k = 0;
        @(negedge clk);
        chk("R1 reset outputs", {mute_o, out_left, out_right}, 49'h0);
    endtask

    task automatic run_table(input string tag);
        for (int i = 0; i < NVEC; i++) begin
            frame(VEC[i][31:16]);
            expect_frame({tag, " R2/R4/R5/R10 vector"}, VEC[i][15], int'(VEC[i][14:0]));
            k++;
        end
    endtask

    // Cancel from an active delay: change frame, then 512 muted frames (R6)
    task automatic run_cancel(input string tag);
        int n;
        frame(16'd0);
        expect_frame({tag, " R6 change frame"}, 1'b1, 0);
        k++;
        n = 0;
        for (int i = 0; i < 600; i++) begin
            frame(16'd0);
            if (!mute_o) break;
            if ({out_left, out_right} != 48'h0) n = n + 10000;
            n++;
            k++;
        end
        chk({tag, " R6 cancel mute length"}, n, 512);
        expect_frame({tag, " R6 pass after cancel"}, 1'b0, 0);
        k++;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    initial begin
        int n;
        // Pass 1: lock error low
        do_reset();
        run_table("pass1");
        run_cancel("pass1");

        // R9: oversized request clamps to 4096
        frame(16'd6000);
        expect_frame("R9 change frame", 1'b1, 0);
        k++;
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            frame(16'd6000);
            if (!mute_o) break;
            n++;
            k++;
        end
        chk("R9 clamped mute length", n, 4096);
        expect_frame("R9 R4 lag at clamp", 1'b0, 4096);
        k++;
        frame(16'd4096);
        expect_frame("R9 4096 same as 6000", 1'b0, 4096);
        k++;

        // Pass 2: lock error high must change nothing (R7)
        lock_err = 1'b1;
        do_reset();
        run_table("R7 lock_err");
        run_cancel("R7 lock_err");
        lock_err = 1'b0;

        finish_run();
    end

endmodule